// File: doc/BRIEF.md
# Branch Condition Evaluator

This block decides whether a conditional branch is taken. A 5-bit selector names the condition. The block tests that condition against the four arithmetic flags (negative, zero, overflow, carry), or against a mask and an operand word for the bit-test forms. The answer is held in a register and appears one clock after the inputs. Target address arithmetic and program counter handling belong to the surrounding core.

The selector covers these groups:
- always-taken and never-taken codes;
- unsigned comparisons;
- signed comparisons;
- single-flag tests;
- two bit-test forms.

Every condition that tests flags is one of a pair. The low selector bit picks the sense within the pair, so codes 0 to 15 run through one shared table. The block only reads the flags and never drives them.

Top module: `branch_cond_eval`

## Requirements
- R1: While `rst` is high at a rising edge of `clk`, `taken` becomes 0 at that edge.
- R2: `taken` shows the decision for the inputs present at the previous rising edge. It holds that value until the next edge.
- R3: Code 0 is always taken. Code 1 is never taken.
- R4: Code 2 (higher) is taken when C and Z are both 0. Code 3 (lower-or-same) is taken when C or Z is 1.
- R5: The single-flag codes are:
  - 4 (carry clear), taken when C=0;
  - 5 (carry set), taken when C=1;
  - 6 (not equal), taken when Z=0;
  - 7 (equal), taken when Z=1;
  - 8 (overflow clear), taken when V=0;
  - 9 (overflow set), taken when V=1;
  - 10 (plus), taken when N=0;
  - 11 (minus), taken when N=1.
- R6: Code 12 (signed greater-or-equal) is taken when N XOR V is 0. Code 13 (signed less-than) is taken when N XOR V is 1.
- R7: Code 14 (signed greater-than) is taken when Z OR (N XOR V) is 0. Code 15 (signed less-or-equal) is taken when Z OR (N XOR V) is 1.
- R8: Code 16 (bits clear) is taken when `bit_mask` AND `bit_operand` is all zero.
- R9: Code 17 (bits set) is taken when every bit set in `bit_mask` is also set in `bit_operand`. That is, `bit_mask` AND NOT `bit_operand` is all zero.
- R10: Codes 18 to 31 are reserved and are never taken.
- R11: The mask and operand inputs have no effect on codes 0 to 15. The four flags have no effect on codes 16 and 17.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| cond_sel | input | 5 | Condition selector code |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_v | input | 1 | Overflow flag |
| flag_c | input | 1 | Carry flag |
| bit_mask | input | DATA_W (8) | Mask for the bit-test forms |
| bit_operand | input | DATA_W (8) | Operand word for the bit-test forms |
| taken | output | 1 | Registered branch decision |

## Verification
The assertions assume the following about the inputs:
- every input holds a known value at each rising edge once reset is released;
- each input is stable around that edge, because a check compares the new `taken` with values captured by `$past` at the edge before.

The stimulus enforces this in two ways. It drives all inputs to defined values before reset is released. It changes inputs only at falling edges, so each input set is presented for a whole cycle.

// File: rtl/bce_pkg.sv
package bce_pkg;
   localparam int SEL_W      = 5;
   localparam int PAIR_CNT   = 8;
   localparam int PAIR_IDX_W = $clog2(PAIR_CNT);

   typedef enum logic [SEL_W-1:0] {
      COND_ALWAYS = 5'd0,  COND_NEVER = 5'd1,
      COND_HI     = 5'd2,  COND_LS    = 5'd3,
      COND_CC     = 5'd4,  COND_CS    = 5'd5,
      COND_NE     = 5'd6,  COND_EQ    = 5'd7,
      COND_VC     = 5'd8,  COND_VS    = 5'd9,
      COND_PL     = 5'd10, COND_MI    = 5'd11,
      COND_GE     = 5'd12, COND_LT    = 5'd13,
      COND_GT     = 5'd14, COND_LE    = 5'd15,
      COND_BCLR   = 5'd16, COND_BSET  = 5'd17
   } cond_code_e;

   typedef struct packed {
      logic n;
      logic z;
      logic v;
      logic c;
   } flags_t;
endpackage

// File: rtl/bce_flag_eval.sv
module bce_flag_eval
   import bce_pkg::*;
(
   input  flags_t                flags,
   input  logic [PAIR_IDX_W-1:0] pair_idx,
   input  logic                  sense_raw,
   output logic                  flag_hit
);
   // Each pair evaluates one raw expression.
   // The odd code of the pair takes it as is; the even code takes its inverse.
   logic [PAIR_CNT-1:0] raw_vec;
   logic                sign_diff;

   always_comb begin
      sign_diff  = flags.n ^ flags.v;
      raw_vec[0] = 1'b0;
      raw_vec[1] = flags.c | flags.z;
      raw_vec[2] = flags.c;
      raw_vec[3] = flags.z;
      raw_vec[4] = flags.v;
      raw_vec[5] = flags.n;
      raw_vec[6] = sign_diff;
      raw_vec[7] = flags.z | sign_diff;
   end

   assign flag_hit = sense_raw ? raw_vec[pair_idx] : ~raw_vec[pair_idx];
endmodule

// File: rtl/bce_mask_eval.sv
module bce_mask_eval #(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] mask,
   input  logic [DATA_W-1:0] operand,
   output logic              none_set,
   output logic              all_set
);
   if (DATA_W < 1) begin : g_bad_width
      $error("bce_mask_eval: DATA_W must be at least 1");
   end

   logic [DATA_W-1:0] hit_vec;
   logic [DATA_W-1:0] miss_vec;

   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      assign hit_vec[i]  = mask[i] & operand[i];
      assign miss_vec[i] = mask[i] & ~operand[i];
   end

   assign none_set = ~|hit_vec;
   assign all_set  = ~|miss_vec;
endmodule

// File: rtl/branch_cond_eval.sv
module branch_cond_eval
   import bce_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [4:0]        cond_sel,
   input  logic              flag_n,
   input  logic              flag_z,
   input  logic              flag_v,
   input  logic              flag_c,
   input  logic [DATA_W-1:0] bit_mask,
   input  logic [DATA_W-1:0] bit_operand,
   output logic              taken
);
   if (DATA_W < 1 || DATA_W > 64) begin : g_bad_width
      $error("branch_cond_eval: DATA_W out of range 1..64");
   end
   if (SEL_W != 5) begin : g_bad_sel
      $error("branch_cond_eval: selector width must be 5");
   end

   flags_t flags;
   logic   flag_hit;
   logic   none_set;
   logic   all_set;
   logic   decision;

   assign flags = '{n: flag_n, z: flag_z, v: flag_v, c: flag_c};

   bce_flag_eval u_flag (
      .flags     (flags),
      .pair_idx  (cond_sel[PAIR_IDX_W:1]),
      .sense_raw (cond_sel[0]),
      .flag_hit  (flag_hit)
   );

   bce_mask_eval #(.DATA_W(DATA_W)) u_mask (
      .mask     (bit_mask),
      .operand  (bit_operand),
      .none_set (none_set),
      .all_set  (all_set)
   );

   always_comb begin
      if (!cond_sel[SEL_W-1])
         decision = flag_hit;
      else if (cond_sel == COND_BCLR)
         decision = none_set;
      else if (cond_sel == COND_BSET)
         decision = all_set;
      else
         decision = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (rst) taken <= 1'b0;
      else     taken <= decision;
   end

   // Checks on the registered decision
   assert_always_R3: assert property (@(posedge clk) disable iff (rst)
      cond_sel == 5'd0 |=> taken);
   assert_never_R3: assert property (@(posedge clk) disable iff (rst)
      cond_sel == 5'd1 |=> !taken);
   assert_higher_R4: assert property (@(posedge clk) disable iff (rst)
      cond_sel == 5'd2 |=> taken == !($past(flag_c) || $past(flag_z)));
   assert_equal_R5: assert property (@(posedge clk) disable iff (rst)
      cond_sel == 5'd7 |=> taken == $past(flag_z));
   assert_ge_R6: assert property (@(posedge clk) disable iff (rst)
      (cond_sel == 5'd12 && flag_n == flag_v) |=> taken);
   assert_le_R7: assert property (@(posedge clk) disable iff (rst)
      (cond_sel == 5'd15 && flag_z) |=> taken);
   assert_bclr_R8: assert property (@(posedge clk) disable iff (rst)
      (cond_sel == 5'd16 && (bit_mask & bit_operand) == '0) |=> taken);
   assert_bset_R9: assert property (@(posedge clk) disable iff (rst)
      (cond_sel == 5'd17 && (bit_mask & ~bit_operand) != '0) |=> !taken);
   assert_reserved_R10: assert property (@(posedge clk) disable iff (rst)
      cond_sel >= 5'd18 |=> !taken);
endmodule

// File: tb/branch_cond_eval_tb_top.sv
`timescale 1ns/100ps
module branch_cond_eval_tb_top;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst;
   logic [4:0]    cond_sel;
   logic          fn, fz, fv, fc;
   logic [DW-1:0] mask, opnd;
   logic          taken;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   branch_cond_eval #(.DATA_W(DW)) dut_i (
      .clk(clk), .rst(rst), .cond_sel(cond_sel),
      .flag_n(fn), .flag_z(fz), .flag_v(fv), .flag_c(fc),
      .bit_mask(mask), .bit_operand(opnd), .taken(taken)
   );

   // Expected decision, taken from the requirement text
   function automatic logic expect_taken(input logic [4:0] s, input logic n, z, v, c,
                                         input logic [DW-1:0] m, o);
      case (s)
         5'd0:  return 1'b1;
         5'd1:  return 1'b0;
         5'd2:  return !c && !z;
         5'd3:  return c || z;
         5'd4:  return !c;
         5'd5:  return c;
         5'd6:  return !z;
         5'd7:  return z;
         5'd8:  return !v;
         5'd9:  return v;
         5'd10: return !n;
         5'd11: return n;
         5'd12: return n == v;
         5'd13: return n != v;
         5'd14: return !(z || (n != v));
         5'd15: return z || (n != v);
         5'd16: return (m & o) == '0;
         5'd17: return (m & ~o) == '0;
         default: return 1'b0;
      endcase
   endfunction

   task automatic check(input string req, input logic exp);
      checks++;
      if (taken !== exp) begin
         fails++;
         $display("FAIL %s: sel=%0d nzvc=%b%b%b%b mask=%h op=%h taken=%b expected=%b",
                  req, cond_sel, fn, fz, fv, fc, mask, opnd, taken, exp);
      end
   endtask

   // Present one set of inputs at the falling edge and check the result after the next rising edge.
   task automatic apply(input string req, input logic [4:0] s, input logic [3:0] nzvc,
                        input logic [DW-1:0] m, o);
      @(negedge clk);
      cond_sel = s; {fn, fz, fv, fc} = nzvc; mask = m; opnd = o;
      @(posedge clk); #1;
      check(req, expect_taken(s, nzvc[3], nzvc[2], nzvc[1], nzvc[0], m, o));
   endtask

   task automatic t_reset;
      @(negedge clk);
      rst = 1'b1; cond_sel = 5'd0;
      @(posedge clk); #1;
      check("R1", 1'b0);
      @(negedge clk); rst = 1'b0;
   endtask

   task automatic t_latency;
      apply("R2", 5'd0, 4'b0000, '0, '0);
      @(negedge clk); cond_sel = 5'd1;
      #1 check("R2", 1'b1);
      @(posedge clk); #1 check("R2", 1'b0);
   endtask

   task automatic t_uncond;
      for (int f = 0; f < 16; f++) begin
         apply("R3", 5'd0, f[3:0], 8'h5A, 8'hA5);
         apply("R3", 5'd1, f[3:0], 8'h00, 8'hFF);
      end
   endtask

   task automatic t_range(input string req, input int lo, input int hi);
      for (int s = lo; s <= hi; s++)
         for (int f = 0; f < 16; f++)
            apply(req, s[4:0], f[3:0], 8'h3C, 8'h0F);
   endtask

   task automatic t_bits;
      logic [DW-1:0] pats [6] = '{8'h00, 8'hFF, 8'h81, 8'h7E, 8'h10, 8'hF0};
      foreach (pats[i]) foreach (pats[j]) begin
         apply("R8", 5'd16, 4'b0000, pats[i], pats[j]);
         apply("R9", 5'd17, 4'b1111, pats[i], pats[j]);
      end
      apply("R8", 5'd16, 4'b0101, 8'h0F, 8'hF0);
      apply("R9", 5'd17, 4'b1010, 8'h0F, 8'h0E);
   endtask

   task automatic t_reserved;
      for (int s = 18; s < 32; s++) begin
         apply("R10", s[4:0], 4'b1111, 8'h00, 8'h00);
         apply("R10", s[4:0], 4'b0000, 8'hFF, 8'hFF);
      end
   endtask

   task automatic t_ignore;
      // Flag codes with contrasting mask/operand words
      for (int s = 0; s < 16; s++) begin
         apply("R11", s[4:0], 4'b0110, 8'h00, 8'h00);
         apply("R11", s[4:0], 4'b0110, 8'hFF, 8'hFF);
      end
      // Bit-test codes under every flag pattern
      for (int f = 0; f < 16; f++) begin
         apply("R11", 5'd16, f[3:0], 8'h0C, 8'h03);
         apply("R11", 5'd17, f[3:0], 8'h0C, 8'h0D);
      end
   endtask

   initial begin
      rst = 1'b1; cond_sel = '0; {fn, fz, fv, fc} = '0; mask = '0; opnd = '0;
      repeat (3) @(posedge clk);
      t_reset;
      t_latency;
      t_uncond;
      t_range("R4", 2, 3);
      t_range("R5", 4, 11);
      t_range("R6", 12, 13);
      t_range("R7", 14, 15);
      t_bits;
      t_reserved;
      t_ignore;
      t_reset;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #(200000 * 5);
      checks++; fails++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule